// File: doc/BRIEF.md
# Ordered Command Stream Sequencer

This block is the control unit of a statically scheduled accelerator. It takes command words that were compiled ahead of time and runs them strictly in the order they arrive. It starts three kinds of work: DMA transfers, labelled with a small tag; barriers that hold dispatch back until chosen transfers have finished; and convolution jobs, which run on a separate compute datapath. The block has no cache and does no dynamic dependency checking. Correct ordering depends only on the barrier commands that the compiler places in the stream.

Commands enter on a valid/ready stream. The block takes one word on each cycle where both `cmd_valid` and `cmd_ready` are high. It lowers `cmd_ready` for as long as it is busy with a command, so a producer must hold the word and `cmd_valid` steady until it is accepted. DMA requests leave on a valid/ready stream of their own. Once a request is raised, its tag and descriptor stay fixed until `dma_req_ready` is seen. Completions, convolution start and done, restart and the two sticky flags are plain level or pulse pins.

Top module: `cmd_stream_seq`

## Requirements
- R1: `cmd_ready` is high only when the block is waiting for a new command. Each handshake consumes exactly one word, and the words are executed in arrival order.
- R2: The opcode sits in bits [31:28]. The codes are 0 = DMA, 1 = WAIT, 2 = CONV and 3 = END. Any other code sets the sticky `err` flag and halts dispatch.
- R3: A DMA command raises `dma_req_valid` on the cycle after it is accepted. The request carries tag = bits [2:0] and descriptor = bits [27:8]. Valid, tag and descriptor stay fixed until `dma_req_ready`, and no further command is fetched before that handshake.
- R4: A tag becomes outstanding on its request handshake. It stops being outstanding when `dma_done_valid` is high with that tag on `dma_done_tag`. Several tags can be outstanding at the same time.
- R5: A WAIT carries a bitmask in bits [7:0]. It blocks fetching until none of the masked tags is outstanding. A completion counts in the cycle it arrives, so `cmd_ready` returns on the cycle after the last masked completion. Outstanding tags outside the mask have no effect.
- R6: A CONV command drives `conv_start` high for exactly one cycle, on the cycle after acceptance. During that pulse `conv_arg` carries bits [27:0]. Fetching stays blocked until a `conv_done` pulse arrives, and a `conv_done` that falls in the start cycle itself is ignored.
- R7: An END command sets the sticky `idle` flag. While `idle` is high, `cmd_ready` stays low whatever `cmd_valid` does.
- R8: A DMA command whose tag is still outstanding sets the sticky `err` flag, issues no request and halts. A completion for that tag arriving in the same cycle as the acceptance frees the tag, and the DMA is then issued normally.
- R9: `restart` clears `idle` or `err` and fetching resumes on the next cycle. Outstanding tags are kept. In any other state, `restart` is ignored.
- R10: After reset, `cmd_ready` is high, and `dma_req_valid`, `conv_start`, `idle` and `err` are low, with no tag outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command word offered |
| cmd_ready | output | 1 | Block will accept a command word |
| cmd_data | input | 32 | Command word |
| dma_req_valid | output | 1 | DMA request offered |
| dma_req_ready | input | 1 | DMA engine takes the request |
| dma_req_tag | output | 3 | Tag of the requested transfer |
| dma_req_desc | output | 20 | Transfer descriptor |
| dma_done_valid | input | 1 | One-cycle completion pulse |
| dma_done_tag | input | 3 | Tag that completed |
| conv_start | output | 1 | One-cycle compute start pulse |
| conv_arg | output | 28 | Compute job argument |
| conv_done | input | 1 | Compute finished pulse |
| restart | input | 1 | Leave the halted or finished state |
| idle | output | 1 | Sticky end-of-stream flag |
| err | output | 1 | Sticky error flag |

## Verification
Two functions can land on the same edge: a transfer completion and the acceptance of a new DMA that uses the same tag. The bench drives both pulses on the same cycle for a tag that is still outstanding. It expects the request to be issued with no error. A second DMA for the now-outstanding tag is then sent with no completion alongside it, and this one must set `err`. A completion arriving while a WAIT is stalled is judged by the exact cycle on which `cmd_ready` comes back.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam logic [3:0] OPC_DMA  = 4'd0;
  localparam logic [3:0] OPC_WAIT = 4'd1;
  localparam logic [3:0] OPC_CONV = 4'd2;
  localparam logic [3:0] OPC_END  = 4'd3;

  typedef enum logic [2:0] {
    ST_FETCH,
    ST_DMA,
    ST_WAIT,
    ST_CSTART,
    ST_CBUSY,
    ST_IDLE,
    ST_ERR
  } seq_state_e;

  typedef struct packed {
    logic is_dma;
    logic is_wait;
    logic is_conv;
    logic is_end;
    logic is_bad;
  } cmd_kind_t;
endpackage

// File: rtl/seq_decode.sv
module seq_decode
  import seq_pkg::*;
#(
  parameter int CMD_W = 32,
  parameter int NTAGS = 8,
  localparam int TAG_W  = $clog2(NTAGS),
  localparam int ARG_W  = CMD_W - 4,
  localparam int DESC_W = ARG_W - NTAGS
) (
  input  logic [CMD_W-1:0]  word,
  output cmd_kind_t         kind,
  output logic [TAG_W-1:0]  tag,
  output logic [NTAGS-1:0]  mask,
  output logic [DESC_W-1:0] desc,
  output logic [ARG_W-1:0]  arg
);
  logic [3:0] opc;

  always_comb begin
    opc  = word[CMD_W-1 -: 4];
    arg  = word[ARG_W-1:0];
    mask = word[NTAGS-1:0];
    tag  = word[TAG_W-1:0];
    desc = word[ARG_W-1:NTAGS];
    kind = '0;
    unique case (opc)
      OPC_DMA:  kind.is_dma  = 1'b1;
      OPC_WAIT: kind.is_wait = 1'b1;
      OPC_CONV: kind.is_conv = 1'b1;
      OPC_END:  kind.is_end  = 1'b1;
      default:  kind.is_bad  = 1'b1;
    endcase
  end
endmodule

// File: rtl/seq_tag_tracker.sv
module seq_tag_tracker #(
  parameter int NTAGS = 8,
  localparam int TAG_W = $clog2(NTAGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [TAG_W-1:0] set_tag,
  input  logic             clr_en,
  input  logic [TAG_W-1:0] clr_tag,
  output logic [NTAGS-1:0] pend_q,
  output logic [NTAGS-1:0] pend_eff
);
  // pend_eff already has this cycle's completion applied, so a
  // decision taken now sees a transfer that finishes now as free.
  for (genvar g = 0; g < NTAGS; g++) begin : g_bit
    logic hit_set, hit_clr;
    assign hit_set     = set_en && (set_tag == TAG_W'(g));
    assign hit_clr     = clr_en && (clr_tag == TAG_W'(g));
    assign pend_eff[g] = pend_q[g] && !hit_clr;

    always_ff @(posedge clk) begin
      if (!rst_n) pend_q[g] <= 1'b0;
      else        pend_q[g] <= pend_eff[g] || hit_set;
    end
  end
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import seq_pkg::*;
#(
  parameter int CMD_W = 32,
  parameter int NTAGS = 8,
  localparam int TAG_W  = $clog2(NTAGS),
  localparam int ARG_W  = CMD_W - 4,
  localparam int DESC_W = ARG_W - NTAGS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  cmd_kind_t         kind,
  input  logic [TAG_W-1:0]  tag_in,
  input  logic [NTAGS-1:0]  mask_in,
  input  logic [DESC_W-1:0] desc_in,
  input  logic [ARG_W-1:0]  arg_in,
  input  logic [NTAGS-1:0]  pend_eff,
  input  logic              dma_req_ready,
  input  logic              conv_done,
  input  logic              restart,
  output seq_state_e        state,
  output logic [TAG_W-1:0]  tag_q,
  output logic [DESC_W-1:0] desc_q,
  output logic [ARG_W-1:0]  arg_q,
  output logic              idle_q,
  output logic              err_q
);
  logic [NTAGS-1:0] mask_q;
  logic             wait_clear;

  assign wait_clear = ((pend_eff & mask_q) == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_FETCH;
      tag_q  <= '0;
      mask_q <= '0;
      desc_q <= '0;
      arg_q  <= '0;
      idle_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      unique case (state)
        ST_FETCH: begin
          if (cmd_valid) begin
            tag_q  <= tag_in;
            mask_q <= mask_in;
            desc_q <= desc_in;
            arg_q  <= arg_in;
            if (kind.is_bad) begin
              state <= ST_ERR;
              err_q <= 1'b1;
            end else if (kind.is_dma) begin
              if (pend_eff[tag_in]) begin
                state <= ST_ERR;
                err_q <= 1'b1;
              end else begin
                state <= ST_DMA;
              end
            end else if (kind.is_wait) begin
              state <= ST_WAIT;
            end else if (kind.is_conv) begin
              state <= ST_CSTART;
            end else begin
              state  <= ST_IDLE;
              idle_q <= 1'b1;
            end
          end
        end
        ST_DMA:    if (dma_req_ready) state <= ST_FETCH;
        ST_WAIT:   if (wait_clear) state <= ST_FETCH;
        ST_CSTART: state <= ST_CBUSY;
        ST_CBUSY:  if (conv_done) state <= ST_FETCH;
        ST_IDLE, ST_ERR: begin
          if (restart) begin
            state  <= ST_FETCH;
            idle_q <= 1'b0;
            err_q  <= 1'b0;
          end
        end
        default: state <= ST_ERR;
      endcase
    end
  end
endmodule

// File: rtl/cmd_stream_seq.sv
module cmd_stream_seq
  import seq_pkg::*;
#(
  parameter int CMD_W = 32,
  parameter int NTAGS = 8,
  localparam int TAG_W  = $clog2(NTAGS),
  localparam int ARG_W  = CMD_W - 4,
  localparam int DESC_W = ARG_W - NTAGS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [CMD_W-1:0]  cmd_data,
  output logic              dma_req_valid,
  input  logic              dma_req_ready,
  output logic [TAG_W-1:0]  dma_req_tag,
  output logic [DESC_W-1:0] dma_req_desc,
  input  logic              dma_done_valid,
  input  logic [TAG_W-1:0]  dma_done_tag,
  output logic              conv_start,
  output logic [ARG_W-1:0]  conv_arg,
  input  logic              conv_done,
  input  logic              restart,
  output logic              idle,
  output logic              err
);
  cmd_kind_t         kind;
  logic [TAG_W-1:0]  dec_tag;
  logic [NTAGS-1:0]  dec_mask;
  logic [DESC_W-1:0] dec_desc;
  logic [ARG_W-1:0]  dec_arg;
  logic [NTAGS-1:0]  pend_q, pend_eff;
  seq_state_e        state;
  logic              req_fire;

  seq_decode #(.CMD_W(CMD_W), .NTAGS(NTAGS)) u_dec (
    .word(cmd_data), .kind(kind), .tag(dec_tag), .mask(dec_mask),
    .desc(dec_desc), .arg(dec_arg)
  );

  assign cmd_ready     = (state == ST_FETCH);
  assign dma_req_valid = (state == ST_DMA);
  assign conv_start    = (state == ST_CSTART);
  assign req_fire      = dma_req_valid && dma_req_ready;

  seq_tag_tracker #(.NTAGS(NTAGS)) u_trk (
    .clk(clk), .rst_n(rst_n),
    .set_en(req_fire), .set_tag(dma_req_tag),
    .clr_en(dma_done_valid), .clr_tag(dma_done_tag),
    .pend_q(pend_q), .pend_eff(pend_eff)
  );

  seq_fsm #(.CMD_W(CMD_W), .NTAGS(NTAGS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .kind(kind),
    .tag_in(dec_tag), .mask_in(dec_mask), .desc_in(dec_desc),
    .arg_in(dec_arg), .pend_eff(pend_eff),
    .dma_req_ready(dma_req_ready), .conv_done(conv_done),
    .restart(restart), .state(state), .tag_q(dma_req_tag),
    .desc_q(dma_req_desc), .arg_q(conv_arg), .idle_q(idle), .err_q(err)
  );
endmodule

// File: rtl/seq_checker.sv
module seq_checker #(
  parameter int NTAGS = 8,
  parameter int DESC_W = 20,
  localparam int TAG_W = $clog2(NTAGS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_ready,
  input logic              dma_req_valid,
  input logic              dma_req_ready,
  input logic [TAG_W-1:0]  dma_req_tag,
  input logic [DESC_W-1:0] dma_req_desc,
  input logic              dma_done_valid,
  input logic [TAG_W-1:0]  dma_done_tag,
  input logic              conv_start,
  input logic              restart,
  input logic              idle,
  input logic              err,
  input logic [NTAGS-1:0]  pend_q
);
  assert_ready_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!dma_req_valid && !conv_start && !idle && !err));

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req_valid && !dma_req_ready) |=>
      (dma_req_valid && $stable(dma_req_tag) && $stable(dma_req_desc)));

  assert_set_on_fire_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req_valid && dma_req_ready) |=> pend_q[$past(dma_req_tag)]);

  assert_clr_on_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_done_valid && !(dma_req_valid && dma_req_ready && dma_req_tag == dma_done_tag))
      |=> !pend_q[$past(dma_done_tag)]);

  assert_start_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  assert_idle_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !restart) |=> (idle && !cmd_ready));

  assert_no_dup_issue_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_req_valid) |-> !pend_q[dma_req_tag]);

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !restart) |=> (err && !dma_req_valid));

  assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((idle || err) && restart) |=> cmd_ready);
endmodule

bind cmd_stream_seq seq_checker #(.NTAGS(NTAGS), .DESC_W(DESC_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready),
  .dma_req_valid(dma_req_valid), .dma_req_ready(dma_req_ready),
  .dma_req_tag(dma_req_tag), .dma_req_desc(dma_req_desc),
  .dma_done_valid(dma_done_valid), .dma_done_tag(dma_done_tag),
  .conv_start(conv_start), .restart(restart), .idle(idle), .err(err),
  .pend_q(pend_q)
);

// File: tb/test_cmd_stream_seq.sv
module test_cmd_stream_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [31:0] cmd_data = '0;
  logic        dma_req_valid;
  logic        dma_rdy = 1'b1;
  logic [2:0]  dma_req_tag;
  logic [19:0] dma_req_desc;
  logic        dma_done_valid = 1'b0;
  logic [2:0]  dma_done_tag = '0;
  logic        conv_start;
  logic [27:0] conv_arg;
  logic        conv_done = 1'b0;
  logic        restart = 1'b0;
  logic        idle, err;

  int vectors = 0;
  int miscompares = 0;
  int conv_seen = 0;
  logic [22:0] exp_dma[$];
  logic [27:0] exp_conv[$];

  always #10 clk = ~clk;

  cmd_stream_seq i_cmd_stream_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .dma_req_valid(dma_req_valid),
    .dma_req_ready(dma_rdy), .dma_req_tag(dma_req_tag),
    .dma_req_desc(dma_req_desc), .dma_done_valid(dma_done_valid),
    .dma_done_tag(dma_done_tag), .conv_start(conv_start),
    .conv_arg(conv_arg), .conv_done(conv_done), .restart(restart),
    .idle(idle), .err(err)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_dma(input logic [2:0] t, input logic [19:0] d);
    return {4'h0, d, 5'h0, t};
  endfunction
  function automatic logic [31:0] mk_wait(input logic [7:0] m);
    return {4'h1, 20'h0, m};
  endfunction
  function automatic logic [31:0] mk_conv(input logic [27:0] a);
    return {4'h2, a};
  endfunction

  // Monitor: samples halfway between a falling and the next rising edge.
  always @(negedge clk) begin
    #5;
    if (rst_n && dma_req_valid && dma_rdy) begin
      vectors++;
      if (exp_dma.size() == 0) begin
        miscompares++;
        $display("FAIL R3: actual unexpected request tag %0h expected none", dma_req_tag);
      end else begin
        logic [22:0] e;
        e = exp_dma.pop_front();
        if ({dma_req_tag, dma_req_desc} !== e) begin
          miscompares++;
          $display("FAIL R3: actual %0h expected %0h", {dma_req_tag, dma_req_desc}, e);
        end
      end
    end
    if (rst_n && conv_start) begin
      conv_seen++;
      vectors++;
      if (exp_conv.size() == 0) begin
        miscompares++;
        $display("FAIL R6: actual unexpected start %0h expected none", conv_arg);
      end else begin
        logic [27:0] e;
        e = exp_conv.pop_front();
        if (conv_arg !== e) begin
          miscompares++;
          $display("FAIL R6: actual %0h expected %0h", conv_arg, e);
        end
      end
    end
  end

  task automatic send_cmd(input logic [31:0] w);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_data  = w;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic send_dma(input logic [2:0] t, input logic [19:0] d);
    exp_dma.push_back({t, d});
    send_cmd(mk_dma(t, d));
  endtask

  task automatic complete(input logic [2:0] t);
    dma_done_valid = 1'b1;
    dma_done_tag   = t;
    @(negedge clk);
    dma_done_valid = 1'b0;
  endtask

  task automatic pulse_restart();
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 ready", cmd_ready, 1);
    chk("R10 outputs", {dma_req_valid, conv_start, idle, err}, 0);

    // R3: back-pressure on the request stream
    dma_rdy = 1'b0;
    send_dma(3'd0, 20'hA1B2C);
    repeat (3) @(negedge clk);
    chk("R3 held valid", dma_req_valid, 1);
    chk("R3 no fetch while held", cmd_ready, 0);
    chk("R3 stable tag", {dma_req_tag, dma_req_desc}, {3'd0, 20'hA1B2C});
    dma_rdy = 1'b1;
    @(negedge clk);
    // R1/R4: back-to-back transfers, several outstanding
    send_dma(3'd1, 20'h00011);
    send_dma(3'd2, 20'hFFFFF);
    @(negedge clk);
    // R5: WAIT on tags 1,2; tag 0 outside the mask stays outstanding
    send_cmd(mk_wait(8'h06));
    repeat (2) @(negedge clk);
    chk("R5 stalled", cmd_ready, 0);
    complete(3'd1);
    chk("R5 still stalled after partial", cmd_ready, 0);
    complete(3'd2);
    chk("R5 resumes next cycle", cmd_ready, 1);

    // R8: same-cycle completion frees tag 0 for a new DMA
    exp_dma.push_back({3'd0, 20'h12345});
    cmd_valid = 1'b1;
    cmd_data = mk_dma(3'd0, 20'h12345);
    dma_done_valid = 1'b1;
    dma_done_tag = 3'd0;
    @(negedge clk);
    cmd_valid = 1'b0;
    dma_done_valid = 1'b0;
    chk("R8 same-cycle free no err", err, 0);
    chk("R8 same-cycle issued", dma_req_valid, 1);
    @(negedge clk);
    // R8: duplicate tag 0 now outstanding
    send_cmd(mk_dma(3'd0, 20'h0BAD0));
    chk("R8 dup sets err", err, 1);
    chk("R8 dup no request", dma_req_valid, 0);
    repeat (2) @(negedge clk);
    chk("R8 halted", cmd_ready, 0);
    // R9: restart clears err, pending kept
    pulse_restart();
    chk("R9 err cleared", err, 0);
    chk("R9 fetch resumes", cmd_ready, 1);
    send_cmd(mk_dma(3'd0, 20'h0BAD1));
    chk("R9 pending kept across restart", err, 1);
    pulse_restart();
    complete(3'd0);
    send_cmd(mk_wait(8'hFF));
    @(negedge clk);
    chk("R4 all tags clear", cmd_ready, 1);

    // R6: compute start pulse; done during start cycle is ignored
    exp_conv.push_back(28'h7654321);
    send_cmd(mk_conv(28'h7654321));
    conv_done = 1'b1;
    @(negedge clk);
    conv_done = 1'b0;
    chk("R6 single pulse", conv_start, 0);
    repeat (2) @(negedge clk);
    chk("R6 blocked until done", cmd_ready, 0);
    conv_done = 1'b1;
    @(negedge clk);
    conv_done = 1'b0;
    chk("R6 resumes after done", cmd_ready, 1);
    chk("R6 one start seen", conv_seen, 1);

    // R2: illegal opcode
    send_cmd({4'hA, 28'h0});
    chk("R2 illegal opcode err", err, 1);
    pulse_restart();
    // R9: restart ignored while running normally
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    chk("R9 restart no effect", {cmd_ready, idle, err}, 3'b100);

    // R7: END, then a word held on the input is not taken
    send_cmd({4'h3, 28'h0});
    chk("R7 idle set", idle, 1);
    exp_dma.push_back({3'd5, 20'h55555});
    cmd_valid = 1'b1;
    cmd_data = mk_dma(3'd5, 20'h55555);
    repeat (3) @(negedge clk);
    chk("R7 no fetch when idle", cmd_ready, 0);
    chk("R7 idle sticky", idle, 1);
    chk("R7 held word not consumed", exp_dma.size(), 1);
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    chk("R9 idle cleared", idle, 0);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R1 held word consumed after restart", dma_req_valid, 1);
    repeat (3) @(negedge clk);
    chk("R1 all expected items seen", exp_dma.size() + exp_conv.size(), 0);
    finish_run();
  end
endmodule